// File: doc/BRIEF.md
# Converter Startup Sequencer

This block turns two reset sources, a power-good level and an active-low external reset pin, into the internal reset for a converter's digital core. While either source is bad, the core is held in reset and the sample output is forced to zero. Once both sources are good, the pin release is brought into the system clock domain. The core reset is then held for a fixed number of system clocks. After that, the output stays muted for a fixed number of sample periods while the filters settle. Only then is data-valid raised.

The sample periods are counted from a one-cycle tick that the sample-rate logic supplies, once per output sample. The interface-mode and data-format pins are captured once, in the first clock after the synchronized release. They are held from then until the next restart. Pulling either source bad at any moment restarts the whole sequence. There is no streaming data path here, so every pin is a plain level or a single-cycle strobe, with no valid/ready handshake.

Top module: `startup_seq`

## Requirements
- R1: `core_rst` is 1 while `pwr_good` is 0 or `rst_pin_n` is 0. A pin left at its default low level keeps the block in reset.
- R2: With `pwr_good` and `rst_pin_n` both 1, `core_rst` falls on rising clock edge number SYNC_STAGES + HOLD_CYCLES, counted from the release. The release edge must come between two clock edges.
- R3: While `core_rst` is 1, `zero_force` is 1 and `data_valid` is 0.
- R4: After `core_rst` falls, `zero_force` stays 1 until MUTE_SAMPLES ticks have been seen. On the clock edge that samples the last of these ticks, `zero_force` goes to 0 and `data_valid` goes to 1. Both then keep these values until a restart.
- R5: A `smp_tick` is counted only while the block is muted and out of reset. Ticks during the reset hold have no effect. Without ticks the output never becomes valid.
- R6: `cfg_mode` and `cfg_fmt` take the values of `mode_pins` and `fmt_pins` on the first clock edge after the synchronized release. They hold those values whatever the pins do afterwards. While a reset source is bad they read 0.
- R7: A reset source turning bad at any time drives `core_rst` to 1, `zero_force` to 1 and `data_valid` to 0 without waiting for a clock edge. The full hold and the full mute count then repeat.
- R8: A low pulse on `rst_pin_n` that covers one rising clock edge is enough to cause the full restart of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| pwr_good | input | 1 | Supply above threshold, active high |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| smp_tick | input | 1 | One-cycle strobe, once per sample period |
| mode_pins | input | MODE_W | Interface-mode selection pins |
| fmt_pins | input | FMT_W | Data-format selection pins |
| core_rst | output | 1 | Internal reset for the digital core, active high |
| zero_force | output | 1 | Forces the sample output to zero |
| data_valid | output | 1 | Output data is valid |
| cfg_mode | output | MODE_W | Captured interface mode |
| cfg_fmt | output | FMT_W | Captured data format |

## Verification
The bench builds the block with HOLD_CYCLES = 8 and MUTE_SAMPLES = 5, keeping two synchronizer stages. At these values the exact edge on which the hold ends and the exact tick that ends the mute can both be checked within a few dozen cycles. They also make it cheap to restart from every phase (hold, mute and run) and to confirm that both counters start again from zero. The default values of 1024 and 18436 differ only in counter width.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_MUTE = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/seq_rst_sync.sv
// Combines the reset sources: assertion is asynchronous, release passes
// through STAGES flops of the system clock.
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic src_ok,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge src_ok) begin
        if (!src_ok) chain[g] <= 1'b0;
        else         chain[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge src_ok) begin
        if (!src_ok) chain[g] <= 1'b0;
        else         chain[g] <= chain[g-1];
      end
    end
  end

  assign rst_n_sync = chain[STAGES-1];

  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (!src_ok)
    $rose(rst_n_sync) |-> $past(chain[0])) else $error("release skipped stages"); // R2
endmodule

// File: rtl/seq_delay_cnt.sv
// Counts enabled advances while run is high; done pulses on the LIMIT-th.
module seq_delay_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic adv,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && adv && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (adv)     cnt <= done ? '0 : cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST) else $error("counter beyond limit"); // R2
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt == '0) else $error("counter not cleared"); // R7
endmodule

// File: rtl/seq_cfg_capture.sv
// Captures the configuration pins once after reset release.
module seq_cfg_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] cfg
);
  logic taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= 1'b0;
      cfg   <= '0;
    end else if (!taken) begin
      taken <= 1'b1;
      cfg   <= pins;
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(taken) |-> $stable(cfg)) else $error("config changed after capture"); // R6
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_CYCLES  = 1024,
  parameter int MUTE_SAMPLES = 18436,
  parameter int MODE_W       = 2,
  parameter int FMT_W        = 2
) (
  input  logic              clk_sys,
  input  logic              pwr_good,
  input  logic              rst_pin_n,
  input  logic              smp_tick,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic [FMT_W-1:0]  fmt_pins,
  output logic              core_rst,
  output logic              zero_force,
  output logic              data_valid,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [FMT_W-1:0]  cfg_fmt
);
  localparam int CFG_W = MODE_W + FMT_W;

  logic             src_ok;
  logic             rst_n_sync;
  logic             hold_done;
  logic             mute_done;
  logic [CFG_W-1:0] cfg_all;
  seq_state_t       state, state_nx;

  assign src_ok = pwr_good & rst_pin_n;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_sys),
    .src_ok     (src_ok),
    .rst_n_sync (rst_n_sync)
  );

  seq_delay_cnt #(.LIMIT(HOLD_CYCLES)) u_hold (
    .clk   (clk_sys),
    .rst_n (rst_n_sync),
    .run   (state == SEQ_HOLD),
    .adv   (1'b1),
    .done  (hold_done)
  );

  seq_delay_cnt #(.LIMIT(MUTE_SAMPLES)) u_mute (
    .clk   (clk_sys),
    .rst_n (rst_n_sync),
    .run   (state == SEQ_MUTE),
    .adv   (smp_tick),
    .done  (mute_done)
  );

  seq_cfg_capture #(.W(CFG_W)) u_cfg (
    .clk   (clk_sys),
    .rst_n (rst_n_sync),
    .pins  ({mode_pins, fmt_pins}),
    .cfg   (cfg_all)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SEQ_HOLD: if (hold_done) state_nx = SEQ_MUTE;
      SEQ_MUTE: if (mute_done) state_nx = SEQ_RUN;
      SEQ_RUN:  state_nx = SEQ_RUN;
      default:  state_nx = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk_sys or negedge rst_n_sync) begin
    if (!rst_n_sync) state <= SEQ_HOLD;
    else             state <= state_nx;
  end

  assign core_rst   = (state == SEQ_HOLD);
  assign zero_force = (state != SEQ_RUN);
  assign data_valid = (state == SEQ_RUN);
  assign cfg_mode   = cfg_all[CFG_W-1:FMT_W];
  assign cfg_fmt    = cfg_all[FMT_W-1:0];

  AST_HOLD_EXIT: assert property (@(posedge clk_sys) disable iff (!rst_n_sync)
    $fell(core_rst) |-> $past(hold_done)) else $error("hold left early"); // R2
  AST_VALID_BY_TICK: assert property (@(posedge clk_sys) disable iff (!rst_n_sync)
    $rose(data_valid) |-> $past(smp_tick) && !$past(core_rst)) else $error("valid without tick"); // R5
  AST_RUN_STICKY: assert property (@(posedge clk_sys) disable iff (!rst_n_sync)
    data_valid |=> data_valid) else $error("valid dropped without restart"); // R4
  AST_MUTE_AFTER_HOLD: assert property (@(posedge clk_sys) disable iff (!rst_n_sync)
    $fell(core_rst) |-> zero_force) else $error("unmuted at reset exit"); // R3
endmodule

// File: tb/startup_seq_tb_top.sv
`timescale 1ns/1ps
module startup_seq_tb_top;
  localparam int SYNC = 2;
  localparam int HOLD = 8;
  localparam int MUTE = 5;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       smp_tick = 1'b0;
  logic [1:0] mode_pins = 2'b00;
  logic [1:0] fmt_pins = 2'b00;
  logic       core_rst, zero_force, data_valid;
  logic [1:0] cfg_mode, cfg_fmt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  startup_seq #(
    .SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .MUTE_SAMPLES(MUTE),
    .MODE_W(2), .FMT_W(2)
  ) dut_i (
    .clk_sys(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n),
    .smp_tick(smp_tick), .mode_pins(mode_pins), .fmt_pins(fmt_pins),
    .core_rst(core_rst), .zero_force(zero_force), .data_valid(data_valid),
    .cfg_mode(cfg_mode), .cfg_fmt(cfg_fmt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    smp_tick = 1'b1;
    step(1);
    smp_tick = 1'b0;
  endtask

  task automatic out_state(input string req, input logic r, input logic z, input logic v);
    chk({req, " core_rst"}, 32'(core_rst), 32'(r));
    chk({req, " zero_force"}, 32'(zero_force), 32'(z));
    chk({req, " data_valid"}, 32'(data_valid), 32'(v));
  endtask

  // release both sources at a negedge, then check the exact hold length
  task automatic release_and_hold(input string req, input logic tick_during);
    pwr_good = 1'b1; rst_pin_n = 1'b1;
    smp_tick = tick_during;
    step(SYNC + HOLD - 1);
    out_state({req, " still held"}, 1'b1, 1'b1, 1'b0);
    smp_tick = 1'b0;
    step(1);
    out_state({req, " hold ended"}, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_reset_state();
    step(3);
    out_state("R1 R3 power-up", 1'b1, 1'b1, 1'b0);
    chk("R6 cfg zero in reset", 32'({cfg_mode, cfg_fmt}), 32'h0);
  endtask

  task automatic t_single_source();
    rst_pin_n = 1'b1; pwr_good = 1'b0;
    step(20);
    out_state("R1 power bad", 1'b1, 1'b1, 1'b0);
    rst_pin_n = 1'b0; pwr_good = 1'b1;
    step(20);
    out_state("R1 pin low", 1'b1, 1'b1, 1'b0);
    pwr_good = 1'b0;
    step(1);
  endtask

  task automatic t_hold_and_cfg();
    mode_pins = 2'b10; fmt_pins = 2'b01;
    release_and_hold("R2 R5", 1'b1);
    chk("R6 captured", 32'({cfg_mode, cfg_fmt}), 32'b1001);
    mode_pins = 2'b01; fmt_pins = 2'b11;
    step(3);
    chk("R6 held after pin change", 32'({cfg_mode, cfg_fmt}), 32'b1001);
  endtask

  task automatic t_mute_count();
    step(30);
    out_state("R5 no ticks", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < MUTE - 1; i++) begin
      pulse_tick();
      step(1);
    end
    out_state("R4 one tick short", 1'b0, 1'b1, 1'b0);
    pulse_tick();
    out_state("R4 last tick", 1'b0, 1'b0, 1'b1);
    step(40);
    out_state("R4 stays valid", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_restart_from_run();
    rst_pin_n = 1'b0;
    #1;
    out_state("R7 async assert", 1'b1, 1'b1, 1'b0);
    chk("R6 cfg cleared", 32'({cfg_mode, cfg_fmt}), 32'h0);
    step(1);
    mode_pins = 2'b11; fmt_pins = 2'b10;
    release_and_hold("R8 short pulse", 1'b0);
    chk("R6 recaptured", 32'({cfg_mode, cfg_fmt}), 32'b1110);
  endtask

  task automatic t_restart_from_mute();
    for (int i = 0; i < 3; i++) pulse_tick();
    out_state("R7 partial mute", 1'b0, 1'b1, 1'b0);
    pwr_good = 1'b0;
    #1;
    out_state("R7 power drop", 1'b1, 1'b1, 1'b0);
    step(1);
    release_and_hold("R7 restart", 1'b0);
    for (int i = 0; i < MUTE - 1; i++) pulse_tick();
    out_state("R7 full count again", 1'b0, 1'b1, 1'b0);
    pulse_tick();
    out_state("R7 valid after full count", 1'b0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(1);
    t_reset_state();
    t_single_source();
    t_hold_and_cfg();
    t_mute_count();
    t_restart_from_run();
    t_restart_from_mute();
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule